// File: doc/BRIEF.md
# DDC EDID Slave Address Pointer

This block is the slave side of a two-wire display data channel. It watches an already synchronised clock line and data line and finds start and stop conditions. It shifts in the device address byte and acknowledges only the display-data addresses it owns. After a write-direction address it takes the next byte as the byte offset into an EDID structure. It then produces a 16-bit address into a 64K byte store, with one-cycle read and write strobes. On reads it returns data on the data line, most significant bit first.

The upper address byte comes from a register that software writes, so an EDID image can sit in any 256-byte block of the space. The lower byte is the pointer that the bus loads and advances. One configuration code lets two EDID images share a 512-byte region. In that code the least significant bit of the upper byte no longer comes from software. It is chosen by the device address: the 128-byte image is reached through the first address pair, and the 256-byte image through the other two pairs.

Top module: `ddc_edid_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `sda_pull`, `mem_rd` and `mem_wr` are 0, and the low pointer byte (`mem_addr[7:0]`) is 00h.
- R2: A device address byte is acknowledged (SDA held low during the ninth clock) only when its upper seven bits are 50h, 51h or 53h, that is bytes A0h/A1h, A2h/A3h or A6h/A7h. For any other address no acknowledge is given, no strobe is issued and the pointer is unchanged until the next start condition.
- R3: After an acknowledged write-direction device address, the next byte is acknowledged and becomes `mem_addr[7:0]`.
- R4: Each further byte written by the master is acknowledged. It causes exactly one single-cycle `mem_wr` with that byte on `mem_wdata`, at the current pointer address. `mem_rd` and `mem_wr` are never high together.
- R5: The low pointer byte steps by one after every data byte moved in either direction. It wraps from FFh to 00h without changing the upper address byte.
- R6: When `map_cfg` is not 2'b10, `mem_addr[15:8]` equals `hi_ptr`.
- R7: When `map_cfg` is 2'b10, `mem_addr[15:9]` equals `hi_ptr[7:1]`. `mem_addr[8]` is 1 after device address A0h/A1h and 0 after A2h/A3h or A6h/A7h.
- R8: A read-direction device address, whether after a start or a repeated start, returns bytes starting at the current pointer. The pointer is kept across the repeated start. Each bit is placed on SDA while SCL is low, and a master acknowledge continues with the next address.
- R9: A master not-acknowledge ends the read: SDA is released and the slave ignores the bus until a start. A stop condition always releases SDA and returns the slave to idle.
- R10: A pulse on `mode_entry` clears the low pointer byte to 00h in the next cycle.
- R11: The slave only starts pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Synchronised bus clock line |
| sda_in | input | 1 | Synchronised bus data line, as seen on the wire |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| hi_ptr | input | 8 | Software-set upper address byte |
| map_cfg | input | 2 | Mapping configuration; 2'b10 selects the shared-region mapping |
| mode_entry | input | 1 | One-cycle pulse on entry into the bidirectional DDC mode |
| mem_addr | output | 16 | Address into the EDID store |
| mem_rd | output | 1 | One-cycle read strobe; data is expected on `mem_rdata` one cycle later |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned by the store |

## Verification
The assertions assume that the clock and data lines only change as a legal two-wire master drives them. Data changes while SCL is low, except to form start and stop conditions. Each SCL phase lasts several clocks, so a fetched byte arrives before the next falling edge. They also assume the master never attempts a start or stop while the slave holds SDA low, and that `hi_ptr` and `map_cfg` stay still during a transfer. The bench master keeps every SCL half period at six clocks and changes data only on the low phase. It drives a stop or repeated start only after the slave has released the line, and it changes the pointer and mapping inputs only while the bus is idle.

// File: rtl/ddc_edid_pkg.sv
package ddc_edid_pkg;

    localparam int BYTE_W = 8;
    localparam logic [1:0] CFG_SHARED = 2'b10;

    // Slave bus state
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_RLOAD,
        ST_HOLD
    } bus_st_e;

    // Which byte of a write transfer is being received
    typedef enum logic [1:0] {
        PH_DEV,
        PH_WORD,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic hit;
        logic v1_sel;
    } dev_dec_t;

    function automatic dev_dec_t decode_dev(input logic [BYTE_W-1:0] b);
        dev_dec_t d;
        d.hit    = (b[7:1] == 7'h50) || (b[7:1] == 7'h51) || (b[7:1] == 7'h53);
        d.v1_sel = (b[7:1] == 7'h50);
        return d;
    endfunction

endpackage

// File: rtl/ddc_line_watch.sv
module ddc_line_watch (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    assign scl_rise   = scl_in & ~scl_q;
    assign scl_fall   = ~scl_in & scl_q;
    assign start_seen = scl_in & scl_q & sda_q & ~sda_in;
    assign stop_seen  = scl_in & scl_q & ~sda_q & sda_in;

endmodule

// File: rtl/ddc_ptr_unit.sv
module ddc_ptr_unit #(
    parameter int PTR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               load,
    input  logic [PTR_W-1:0]   load_val,
    input  logic               step,
    input  logic [PTR_W-1:0]   hi_ptr,
    input  logic [1:0]         map_cfg,
    input  logic               v1_sel,
    output logic [2*PTR_W-1:0] addr
);
    import ddc_edid_pkg::*;

    logic [PTR_W-1:0] lo_q;
    logic [PTR_W-1:0] hi_eff;

    // clear beats load beats step; the low byte never carries upward
    always_ff @(posedge clk) begin
        if (rst || clear)
            lo_q <= '0;
        else if (load)
            lo_q <= load_val;
        else if (step)
            lo_q <= lo_q + 1'b1;
    end

    always_comb begin
        hi_eff = hi_ptr;
        if (map_cfg == CFG_SHARED)
            hi_eff[0] = v1_sel;
    end

    assign addr = {hi_eff, lo_q};

endmodule

// File: rtl/ddc_edid_port.sv
module ddc_edid_port #(
    parameter int PTR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_pull,
    input  logic [PTR_W-1:0]    hi_ptr,
    input  logic [1:0]          map_cfg,
    input  logic                mode_entry,
    output logic [2*PTR_W-1:0]  mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata
);
    import ddc_edid_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] BITS_IN  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(BYTE_W - 1);

    logic scl_rise, scl_fall, start_seen, stop_seen;

    bus_st_e          st;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       sr;
    logic [7:0]       tx;
    logic [7:0]       rd_buf;
    logic             rw;
    logic             v1_sel;
    logic             rd_req;
    logic             rd_q;
    logic             wr_req;
    logic [7:0]       wdata;
    dev_dec_t         dec;
    logic             byte_in;
    logic             ptr_load;
    logic             ptr_step;

    ddc_line_watch u_watch (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    assign dec      = decode_dev(sr);
    assign byte_in  = (st == ST_RX) && scl_fall && (cnt == BITS_IN) &&
                      !start_seen && !stop_seen;
    assign ptr_load = byte_in && (phase == PH_WORD);
    assign ptr_step = wr_req ||
                      ((st == ST_MACK) && scl_rise && !start_seen && !stop_seen);

    ddc_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .clear    (mode_entry),
        .load     (ptr_load),
        .load_val (sr[PTR_W-1:0]),
        .step     (ptr_step),
        .hi_ptr   (hi_ptr),
        .map_cfg  (map_cfg),
        .v1_sel   (v1_sel),
        .addr     (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            phase    <= PH_DEV;
            cnt      <= '0;
            sr       <= '0;
            tx       <= '0;
            rd_buf   <= '0;
            rw       <= 1'b0;
            v1_sel   <= 1'b0;
            rd_req   <= 1'b0;
            rd_q     <= 1'b0;
            wr_req   <= 1'b0;
            wdata    <= '0;
            sda_pull <= 1'b0;
        end else begin
            rd_req <= 1'b0;
            wr_req <= 1'b0;
            rd_q   <= rd_req;
            if (rd_q)
                rd_buf <= mem_rdata;

            if (stop_seen) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (start_seen) begin
                st       <= ST_RX;
                phase    <= PH_DEV;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise && cnt != BITS_IN) begin
                            sr  <= {sr[6:0], sda_in};
                            cnt <= cnt + 1'b1;
                        end else if (byte_in) begin
                            case (phase)
                                PH_DEV: begin
                                    if (dec.hit) begin
                                        sda_pull <= 1'b1;
                                        rw       <= sr[0];
                                        v1_sel   <= dec.v1_sel;
                                        st       <= ST_ACK;
                                    end else begin
                                        st <= ST_HOLD;
                                    end
                                end
                                PH_WORD: begin
                                    sda_pull <= 1'b1;
                                    st       <= ST_ACK;
                                end
                                default: begin
                                    sda_pull <= 1'b1;
                                    st       <= ST_ACK;
                                    wr_req   <= 1'b1;
                                    wdata    <= sr;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_rise && phase == PH_DEV && rw) begin
                            rd_req <= 1'b1;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (phase == PH_DEV && rw) begin
                                tx       <= rd_buf;
                                sda_pull <= ~rd_buf[7];
                                st       <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                st       <= ST_RX;
                                phase    <= (phase == PH_DEV) ? PH_WORD : PH_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == LAST_OUT) begin
                                sda_pull <= 1'b0;
                                st       <= ST_MACK;
                            end else begin
                                tx       <= {tx[6:0], 1'b0};
                                sda_pull <= ~tx[6];
                                cnt      <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            rd_req <= ~sda_in;
                            st     <= sda_in ? ST_HOLD : ST_RLOAD;
                        end
                    end
                    ST_RLOAD: begin
                        if (scl_fall) begin
                            tx       <= rd_buf;
                            sda_pull <= ~rd_buf[7];
                            cnt      <= '0;
                            st       <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign mem_rd    = rd_req;
    assign mem_wr    = wr_req;
    assign mem_wdata = wdata;

endmodule

// File: rtl/ddc_edid_port_chk.sv
module ddc_edid_port_chk #(
    parameter int LW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            scl_in,
    input logic            sda_in,
    input logic            sda_pull,
    input logic [LW-1:0]   hi_ptr,
    input logic [1:0]      map_cfg,
    input logic            mode_entry,
    input logic [2*LW-1:0] mem_addr,
    input logic            mem_rd,
    input logic            mem_wr
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R5
    wr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mode_entry) |=> (mem_addr[LW-1:0] == $past(mem_addr[LW-1:0]) + 1'b1));

    // R10
    entry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mode_entry |=> (mem_addr[LW-1:0] == '0));

    // R6
    plain_map_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && map_cfg != 2'b10) |-> (mem_addr[2*LW-1:LW] == hi_ptr));

    // R7
    shared_map_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && map_cfg == 2'b10) |-> (mem_addr[2*LW-1:LW+1] == hi_ptr[LW-1:1]));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_in && $past(scl_in) && !$past(sda_in) && sda_in) |=> !sda_pull);

    // R11
    pull_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_in);

endmodule

bind ddc_edid_port ddc_edid_port_chk #(.LW(PTR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .sda_pull   (sda_pull),
    .hi_ptr     (hi_ptr),
    .map_cfg    (map_cfg),
    .mode_entry (mode_entry),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr)
);

// File: tb/sim_ddc_edid_port.sv
`timescale 1ns/1ps
module sim_ddc_edid_port;

    localparam int Q = 6;

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        msda = 1'b1;
    logic        sda_line;
    logic        sda_pull;
    logic [7:0]  hi_ptr = 8'h12;
    logic [1:0]  map_cfg = 2'b00;
    logic        mode_entry = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int vectors = 0;
    int miscompares = 0;
    int drive_bad = 0;
    bit done = 0;
    wr_item_t exp_q[$];

    always #2.5 clk = ~clk;

    assign sda_line = msda & ~sda_pull;

    ddc_edid_port u0 (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl),
        .sda_in     (sda_line),
        .sda_pull   (sda_pull),
        .hi_ptr     (hi_ptr),
        .map_cfg    (map_cfg),
        .mode_entry (mode_entry),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return a[7:0] ^ {a[8], a[15:9]};
    endfunction

    // store model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= pattern(mem_addr);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write monitor: pops the scoreboard on every write strobe (R4)
    always @(negedge clk) begin
        if (!rst && mem_wr) begin
            if (exp_q.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R4 unexpected write actual=%h expected=none", {mem_addr, mem_wdata});
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk("R4 write addr/data", {8'h00, mem_addr, mem_wdata}, {8'h00, it.a, it.d});
            end
        end
    end

    // R11 drive-edge monitor
    logic prev_pull = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_pull && !prev_pull && scl)
            drive_bad++;
        prev_pull <= sda_pull;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; tick(Q);
        scl  = 1'b1; tick(Q);
        msda = 1'b0; tick(Q);
        scl  = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        msda = 1'b0; tick(Q);
        scl  = 1'b1; tick(Q);
        msda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; tick(Q);
            scl = 1'b1; tick(Q);
            scl = 1'b0;
        end
        msda = 1'b1; tick(Q);
        scl = 1'b1; tick(Q/2);
        ack = ~sda_line;
        tick(Q - Q/2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        msda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q/2);
            b[i] = sda_line;
            tick(Q - Q/2);
            scl = 1'b0;
        end
        msda = mack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0;
        msda = 1'b1;
    endtask

    // driver: writes, pushing expected items into the scoreboard
    task automatic wr_xfer(input logic [7:0] dev, input logic [7:0] word,
                           input logic [7:0] d0, input int n, input logic [15:0] base);
        logic ack;
        logic [7:0] lo;
        bus_start();
        send_byte(dev, ack);  chk("R2 device ack", ack, 1);
        send_byte(word, ack); chk("R3 word ack", ack, 1);
        lo = word;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back({base[15:8], lo, d0 + 8'(k)});
            send_byte(d0 + 8'(k), ack); chk("R4 data ack", ack, 1);
            lo = lo + 8'd1;
        end
        bus_stop();
    endtask

    // random read: set word, repeated start, read n bytes
    task automatic rd_xfer(input logic [7:0] wdev, input logic [7:0] rdev,
                           input logic [7:0] word, input int n, input logic [15:0] base);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(wdev, ack); chk("R2 device ack", ack, 1);
        send_byte(word, ack); chk("R3 word ack", ack, 1);
        bus_start();
        send_byte(rdev, ack); chk("R8 read device ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k != n - 1);
            chk("R8 read data", b, pattern({base[15:8], word + 8'(k)}));
        end
        tick(2);
        chk("R9 release after nack", sda_pull, 0);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        tick(2);
        // R1 reset state
        chk("R1 pull", sda_pull, 0);
        chk("R1 strobes", {mem_rd, mem_wr}, 0);
        chk("R1 R6 addr", mem_addr, 16'h1200);
        tick(3);
        rst = 1'b0;
        tick(4);
        chk("R1 after reset", {sda_pull, mem_rd, mem_wr, mem_addr}, {3'b000, 16'h1200});

        // plain mapping, writes with increment
        wr_xfer(8'hA0, 8'h10, 8'h55, 2, 16'h1200);
        chk("R5 R6 pointer after write", mem_addr, 16'h1212);

        // random read through repeated start
        rd_xfer(8'hA0, 8'hA1, 8'h20, 3, 16'h1200);
        chk("R5 R8 pointer after read", mem_addr, 16'h1223);

        // wrap of the low byte
        wr_xfer(8'hA0, 8'hFE, 8'h90, 3, 16'h1200);
        chk("R5 wrap", mem_addr, 16'h1201);

        // foreign device addresses ignored
        bus_start();
        send_byte(8'hA4, ack); chk("R2 no ack A4", ack, 0);
        send_byte(8'h00, ack); chk("R2 ignored byte", ack, 0);
        send_byte(8'h77, ack); chk("R2 ignored byte", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA8, ack); chk("R2 no ack A8", ack, 0);
        bus_stop();
        chk("R2 pointer unchanged", mem_addr, 16'h1201);

        // shared-region mapping
        hi_ptr = 8'h35; map_cfg = 2'b10;
        wr_xfer(8'hA0, 8'h05, 8'h11, 1, 16'h3500);
        wr_xfer(8'hA2, 8'h05, 8'h22, 1, 16'h3400);
        wr_xfer(8'hA6, 8'h80, 8'h33, 1, 16'h3400);
        rd_xfer(8'hA2, 8'hA3, 8'h40, 2, 16'h3400);
        chk("R7 pointer after v2 read", mem_addr, 16'h3442);
        hi_ptr = 8'h34;
        rd_xfer(8'hA0, 8'hA1, 8'h7F, 1, 16'h3500);
        chk("R7 bit forced to one", mem_addr, 16'h3580);

        // mode entry clears low byte, current-address read
        mode_entry = 1'b1; tick(1); mode_entry = 1'b0; tick(1);
        chk("R10 clear", mem_addr, 16'h3500);
        bus_start();
        send_byte(8'hA1, ack); chk("R8 current read ack", ack, 1);
        recv_byte(b, 1'b0);
        chk("R8 R10 current read data", b, pattern(16'h3500));
        tick(2);
        chk("R9 release", sda_pull, 0);
        bus_stop();
        chk("R5 after current read", mem_addr, 16'h3501);

        // odd upper byte kept when not shared
        hi_ptr = 8'h35; map_cfg = 2'b01;
        wr_xfer(8'hA2, 8'h01, 8'h44, 1, 16'h3500);
        chk("R6 plain odd upper", mem_addr, 16'h3502);

        tick(20);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        chk("R11 pull only while low", drive_bad, 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule